// File: doc/BRIEF.md
# Write Completion Status Readout

This block sits on the read path of a byte-alterable nonvolatile memory. While the write controller runs an internal programming cycle, a read of the byte that was written last does not return array contents. It returns a status word instead. Bit 7 of that word is the inverse of bit 7 of the last written byte. Bit 6 changes value on every new read. Bits 5 to 0 are zero. Host software can detect completion in either of two ways: wait until bit 7 matches the data it wrote, or wait until bit 6 stops changing between reads.

When the controller drops its busy flag, the array data passes through unchanged again. A write that was rejected because the device is protected does not produce the inverted-bit indication. The data bus is modelled as a value plus an enable, and the enable is high only while both active-low strobes are asserted.

Top module: `wr_status_rd`

## Requirements
- R1: `bus_en_o` is 1 exactly when `ce_n_i` and `oe_n_i` are both 0.
- R2: While `bus_en_o` is 0, `bus_q_o` is all zeros.
- R3: During a read with `busy_i`=1, `blocked_i`=0 and `rd_addr_i` equal to `last_addr_i`, `bus_q_o[7]` equals the inverse of `last_data_i[7]`.
- R4: Under the conditions of R3, `bus_q_o[6]` sampled in one read differs from its value in the next such read. The value is sampled at least one clock after the read starts. Its starting value is not fixed.
- R5: Under the conditions of R3, `bus_q_o[5:0]` are all zero.
- R6: During a read with `busy_i`=0, `bus_q_o` equals `arr_data_i`, so bit 7 is the true stored bit and bit 6 no longer alternates.
- R7: During a read with `blocked_i`=1, `bus_q_o` equals `arr_data_i` even when `busy_i`=1.
- R8: During a read with `busy_i`=1 and `rd_addr_i` different from `last_addr_i`, `bus_q_o` equals `arr_data_i`.
- R9: A read of any other address while busy does not advance the bit 6 state. Two reads of the last address with one such read between them still show different bit 6 values.
- R10: The bit 6 state advances once per read, on the clock after both strobes become active. `bus_q_o[6]` then holds steady for the rest of that read, however long it lasts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| busy_i | input | 1 | Programming cycle in progress |
| blocked_i | input | 1 | Last write attempt was rejected by protection |
| last_addr_i | input | AW | Address of last written byte |
| last_data_i | input | DW | Data of last written byte |
| rd_addr_i | input | AW | Read address |
| arr_data_i | input | DW | Array data for the read address |
| ce_n_i | input | 1 | Chip enable, active low |
| oe_n_i | input | 1 | Output enable, active low |
| bus_q_o | output | DW | Read data bus value |
| bus_en_o | output | 1 | Bus drive enable (0 models high impedance) |

## Verification
The hardest case to reach from the ports is proving that the alternating bit advances once per read: not per clock, and not on reads of unrelated addresses. Because its starting value is free, no single read can show this. The stimulus therefore issues pairs of reads of the last address, some held for many clocks and some with a read of a different address between them. It compares bit 6 across each pair rather than against a fixed value.

// File: rtl/wr_status_pkg.sv
package wr_status_pkg;
  function automatic logic [7:0] status_word(input logic [7:0] last_d, input logic tgl);
    status_word = {~last_d[7], tgl, 6'b000000};
  endfunction

  function automatic logic addr_hit(input logic [31:0] a, input logic [31:0] b);
    addr_hit = (a == b);
  endfunction
endpackage

// File: rtl/wr_status_rd_edge.sv
module wr_status_rd_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n_i,
  input  logic oe_n_i,
  output logic rd_act_o,
  output logic rd_rise_o
);
  logic rd_q;

  assign rd_act_o  = ~ce_n_i & ~oe_n_i;
  assign rd_rise_o = rd_act_o & ~rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= 1'b0;
    else        rd_q <= rd_act_o;
  end
endmodule

// File: rtl/wr_status_tgl.sv
module wr_status_tgl (
  input  logic clk,
  input  logic rst_n,
  input  logic adv_i,
  output logic tgl_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     tgl_o <= 1'b0;
    else if (adv_i) tgl_o <= ~tgl_o;
  end
endmodule

// File: rtl/wr_status_mux.sv
module wr_status_mux #(
  parameter int DW = 8
) (
  input  logic          rd_act_i,
  input  logic          stat_sel_i,
  input  logic [DW-1:0] stat_i,
  input  logic [DW-1:0] arr_i,
  output logic [DW-1:0] bus_q_o,
  output logic          bus_en_o
);
  always_comb begin
    bus_en_o = rd_act_i;
    if (!rd_act_i)      bus_q_o = '0;
    else if (stat_sel_i) bus_q_o = stat_i;
    else                bus_q_o = arr_i;
  end
endmodule

// File: rtl/wr_status_rd.sv
module wr_status_rd #(
  parameter int AW = 19,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          busy_i,
  input  logic          blocked_i,
  input  logic [AW-1:0] last_addr_i,
  input  logic [DW-1:0] last_data_i,
  input  logic [AW-1:0] rd_addr_i,
  input  logic [DW-1:0] arr_data_i,
  input  logic          ce_n_i,
  input  logic          oe_n_i,
  output logic [DW-1:0] bus_q_o,
  output logic          bus_en_o
);
  import wr_status_pkg::*;

  localparam int POLL_BIT = DW - 1;
  localparam int TGL_BIT  = DW - 2;

  logic          rd_act_w;
  logic          rd_rise_w;
  logic          hit_w;
  logic          stat_sel_w;
  logic          tgl_adv_w;
  logic          tgl_w;
  logic [DW-1:0] stat_w;
  logic [7:0]    stat8_w;

  wr_status_rd_edge u_edge (
    .clk(clk), .rst_n(rst_n), .ce_n_i(ce_n_i), .oe_n_i(oe_n_i),
    .rd_act_o(rd_act_w), .rd_rise_o(rd_rise_w)
  );

  assign hit_w      = addr_hit(32'(rd_addr_i), 32'(last_addr_i));
  assign stat_sel_w = busy_i & ~blocked_i & hit_w;
  assign tgl_adv_w  = rd_rise_w & stat_sel_w;

  wr_status_tgl u_tgl (
    .clk(clk), .rst_n(rst_n), .adv_i(tgl_adv_w), .tgl_o(tgl_w)
  );

  assign stat8_w = status_word({last_data_i[POLL_BIT], 7'b0}, tgl_w);

  always_comb begin
    stat_w           = '0;
    stat_w[POLL_BIT] = stat8_w[7];
    stat_w[TGL_BIT]  = stat8_w[6];
  end

  wr_status_mux #(.DW(DW)) u_mux (
    .rd_act_i(rd_act_w), .stat_sel_i(stat_sel_w), .stat_i(stat_w),
    .arr_i(arr_data_i), .bus_q_o(bus_q_o), .bus_en_o(bus_en_o)
  );
endmodule

// File: rtl/wr_status_rd_chk.sv
module wr_status_rd_chk #(
  parameter int AW = 19,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy_i,
  input logic          blocked_i,
  input logic [AW-1:0] last_addr_i,
  input logic [DW-1:0] last_data_i,
  input logic [AW-1:0] rd_addr_i,
  input logic [DW-1:0] arr_data_i,
  input logic          ce_n_i,
  input logic          oe_n_i,
  input logic [DW-1:0] bus_q_o,
  input logic          bus_en_o,
  input logic          stat_sel_w,
  input logic          rd_rise_w
);
  // R1
  en_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_en_o |-> (!ce_n_i && !oe_n_i));
  // R2
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_en_o |-> (bus_q_o == '0));
  // R3
  poll_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en_o && busy_i && !blocked_i && rd_addr_i == last_addr_i)
      |-> (bus_q_o[DW-1] == ~last_data_i[DW-1]));
  // R5
  resv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en_o && busy_i && !blocked_i && rd_addr_i == last_addr_i)
      |-> (bus_q_o[DW-3:0] == '0));
  // R6
  done_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en_o && !busy_i) |-> (bus_q_o == arr_data_i));
  // R7
  blocked_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en_o && blocked_i) |-> (bus_q_o == arr_data_i));
  // R10
  tgl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_sel_w && bus_en_o && !rd_rise_w && $past(stat_sel_w) && $past(bus_en_o)
      && !$past(rd_rise_w) && $past(rst_n)) |-> $stable(bus_q_o[DW-2]));
endmodule

bind wr_status_rd wr_status_rd_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy_i(busy_i), .blocked_i(blocked_i),
  .last_addr_i(last_addr_i), .last_data_i(last_data_i), .rd_addr_i(rd_addr_i),
  .arr_data_i(arr_data_i), .ce_n_i(ce_n_i), .oe_n_i(oe_n_i),
  .bus_q_o(bus_q_o), .bus_en_o(bus_en_o),
  .stat_sel_w(stat_sel_w), .rd_rise_w(rd_rise_w)
);

// File: tb/wr_status_rd_bench.sv
module wr_status_rd_bench;
  localparam int AW = 19;
  localparam int DW = 8;

  logic clk = 0, rst_n = 0;
  logic busy = 0, blocked = 0;
  logic [AW-1:0] last_addr = '0, rd_addr = '0;
  logic [DW-1:0] last_data = '0, arr_data = '0;
  logic ce_n = 1, oe_n = 1;
  logic [DW-1:0] bus_q;
  logic bus_en;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  wr_status_rd #(.AW(AW), .DW(DW)) u_wr_status_rd (
    .clk(clk), .rst_n(rst_n), .busy_i(busy), .blocked_i(blocked),
    .last_addr_i(last_addr), .last_data_i(last_data), .rd_addr_i(rd_addr),
    .arr_data_i(arr_data), .ce_n_i(ce_n), .oe_n_i(oe_n),
    .bus_q_o(bus_q), .bus_en_o(bus_en)
  );

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // one read of hold cycles; returns bus value sampled mid-read (negedge)
  task automatic do_read(input logic [AW-1:0] a, input int hold, output logic [DW-1:0] v);
    @(negedge clk);
    rd_addr = a; ce_n = 0; oe_n = 0;
    repeat (hold) @(negedge clk);
    v = bus_q;
    chk("R1", {7'b0, bus_en}, 8'h01);
    ce_n = 1; oe_n = 1;
    @(negedge clk);
  endtask

  task automatic t_idle;
    @(negedge clk);
    chk("R1", {7'b0, bus_en}, 8'h00);
    chk("R2", bus_q, 8'h00);
    ce_n = 0; oe_n = 1; #1;
    chk("R1", {7'b0, bus_en}, 8'h00);
    chk("R2", bus_q, 8'h00);
    ce_n = 1; oe_n = 0; #1;
    chk("R1", {7'b0, bus_en}, 8'h00);
    oe_n = 1;
  endtask

  task automatic t_poll(input logic [DW-1:0] d);
    logic [DW-1:0] v;
    last_addr = 19'h1A2B3; last_data = d; arr_data = 8'h5C; busy = 1;
    do_read(19'h1A2B3, 3, v);
    chk("R3", {7'b0, v[7]}, {7'b0, ~d[7]});
    chk("R5", {2'b0, v[5:0]}, 8'h00);
  endtask

  task automatic t_toggle;
    logic [DW-1:0] a, b, c;
    busy = 1; last_addr = 19'h00400; last_data = 8'h81;
    do_read(19'h00400, 2, a);
    do_read(19'h00400, 2, b);
    do_read(19'h00400, 2, c);
    chk("R4", {7'b0, a[6] ^ b[6]}, 8'h01);
    chk("R4", {7'b0, b[6] ^ c[6]}, 8'h01);
    // R10: long read holds bit 6 steady and advances only once
    @(negedge clk);
    rd_addr = 19'h00400; ce_n = 0; oe_n = 0;
    repeat (2) @(negedge clk);
    a = bus_q;
    repeat (20) @(negedge clk);
    b = bus_q;
    ce_n = 1; oe_n = 1;
    @(negedge clk);
    chk("R10", {7'b0, a[6]}, {7'b0, b[6]});
    chk("R10", {7'b0, a[6]}, {7'b0, ~c[6]});
  endtask

  task automatic t_other;
    logic [DW-1:0] a, o, b;
    busy = 1; last_addr = 19'h00777; last_data = 8'h7E; arr_data = 8'hC3;
    do_read(19'h00777, 2, a);
    do_read(19'h00778, 2, o);
    do_read(19'h00777, 2, b);
    chk("R8", o, 8'hC3);
    chk("R9", {7'b0, a[6] ^ b[6]}, 8'h01);
  endtask

  task automatic t_done;
    logic [DW-1:0] a, b;
    busy = 0; last_addr = 19'h00010; last_data = 8'h9A; arr_data = 8'h9A;
    do_read(19'h00010, 2, a);
    do_read(19'h00010, 2, b);
    chk("R6", a, 8'h9A);
    chk("R6", b, 8'h9A);
  endtask

  task automatic t_blocked;
    logic [DW-1:0] a;
    busy = 1; blocked = 1; last_addr = 19'h00020; last_data = 8'h12; arr_data = 8'h34;
    do_read(19'h00020, 2, a);
    chk("R7", a, 8'h34);
    blocked = 0;
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        chk("R2", bus_q, 8'h00);
        rst_n = 1;
        t_idle;
        t_poll(8'h35);
        t_poll(8'hA0);
        t_toggle;
        t_other;
        t_done;
        t_blocked;
      end
      begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog act=hung exp=done");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule